// File: doc/BRIEF.md
# Buzzer Square-Wave Tone Generator

This block produces a square wave on a single buzzer output. Software writes a divider value over a byte-wide write strobe bus. The value is split into bytes. Every byte except the most significant one lands only in a holding buffer. Writing the most significant byte transfers the whole value into the live divider register in one step. A down-counter, stepped once per cycle of a source-clock enable (`tick_en`), reloads from the live value each time it reaches zero. Each reload flips a phase flip-flop, so the output period is twice the divide ratio.

A small configuration register holds a run bit and a modulation bit. Clearing the run bit freezes the counter and the output at their present levels. A live value of zero overrides everything else and drives the output high. When modulation is on, an external gate input decides whether the square wave reaches the pin or the pin rests high. The gate polarity is a parameter.

Top module: `buzz_tone_gen`

## Requirements
- R1: A write to any address below the top byte address (address 0 holds bits 7:0 by default) changes only the holding buffer. The live divider value and the output period stay as they were.
- R2: A write to the top byte address (address 1 by default) loads the live value with the written byte above the buffered lower bytes, all in the same cycle.
- R3: While the live value is zero, `bz_out` is high, whatever the configuration and the gate.
- R4: With live value N (1 to 65535) and `tick_en` held high, each output half period lasts N+1 clock cycles. N=1 gives the shortest half period, 2 cycles.
- R5: After a zero live value is replaced by a non-zero one with the run bit set, the first cycle with `tick_en` high drives `bz_out` low at that clock edge.
- R6: Clearing the run bit holds `bz_out` at its present level, provided the live value is non-zero. Setting the bit again resumes toggling.
- R7: With the modulation bit set, `bz_out` is high while the gate is idle (`mod_gate` low by default) and carries the square wave while the gate is active. With the modulation bit clear, the gate has no effect.
- R8: A new live value written in the middle of a count takes effect only at the next reload. The half period under way finishes with the old ratio.
- R9: After reset the buffer, the live value and the configuration are all zero, and `bz_out` is high.
- R10: The configuration register sits at the address just above the top byte (address 2 by default). Data bit 0 is the run bit and data bit 1 is the modulation bit.
- R11: The counter and the phase advance only in cycles with `tick_en` high. With `tick_en` high one cycle in three and N=1, a half period lasts 6 clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable from the chosen source clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 8 | Write data byte |
| mod_gate | input | 1 | External modulation gate |
| bz_out | output | 1 | Buzzer square-wave output |

## Verification
The bench measures half periods across a range of divider values, including the minimum ratio and a value that needs the top byte. A design that committed the low byte on its own write would change the measured period straight after that write. A design that reloaded immediately on a high-byte write, instead of at the next terminal count, would cut short the half period under way. The bench also checks that a zero value parks the output high and that clearing the run bit freezes the level rather than forcing it. It checks that an idle gate under modulation pins the output high, and that a sparse `tick_en` stretches the period in proportion. A design that ignored the enable, or that let the gate act with modulation off, would show a wrong period or a stuck level.

// File: rtl/buzz_pkg.sv
package buzz_pkg;
   localparam int BYTE_W      = 8;
   localparam int CFG_RUN_BIT = 0;
   localparam int CFG_MOD_BIT = 1;

   typedef struct packed {
      logic mod_on;
      logic run_on;
   } buzz_cfg_t;
endpackage

// File: rtl/buzz_regs.sv
module buzz_regs
   import buzz_pkg::*;
#(
   parameter int DIV_W  = 16,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [DIV_W-1:0]  live_val,
   output logic [DIV_W-BYTE_W-1:0] shadow_val,
   output logic              live_zero,
   output buzz_cfg_t         cfg_q
);
   localparam int NBYTES   = DIV_W / BYTE_W;
   localparam int TOP_IDX  = NBYTES - 1;
   localparam int LOW_W    = DIV_W - BYTE_W;
   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(TOP_IDX);
   localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(NBYTES);

   logic [LOW_W-1:0] shadow_q;
   logic [DIV_W-1:0] live_q;

   // holding bytes: one register slice per lower byte
   for (genvar k = 0; k < TOP_IDX; k++) begin : g_hold
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q[k*BYTE_W +: BYTE_W] <= '0;
         end else if (wr_en && (wr_addr == MY_ADDR)) begin
            shadow_q[k*BYTE_W +: BYTE_W] <= wr_data;
         end
      end
   end

   // atomic commit on top byte write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
      end else if (wr_en && (wr_addr == TOP_ADDR)) begin
         live_q <= {wr_data, shadow_q};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_en && (wr_addr == CFG_ADDR)) begin
         cfg_q.run_on <= wr_data[CFG_RUN_BIT];
         cfg_q.mod_on <= wr_data[CFG_MOD_BIT];
      end
   end

   assign live_val   = live_q;
   assign shadow_val = shadow_q;
   assign live_zero  = (live_q == '0);
endmodule

// File: rtl/buzz_divider.sv
module buzz_divider #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             run,
   input  logic             zero,
   input  logic [DIV_W-1:0] load_val,
   output logic             term
);
   logic [DIV_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == '0);
   assign term   = tick_en && run && !zero && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (zero) begin
         cnt_q <= '0;
      end else if (tick_en && run) begin
         if (at_end) begin
            cnt_q <= load_val;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/buzz_out_stage.sv
module buzz_out_stage #(
   parameter bit GATE_ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic term,
   input  logic run,
   input  logic zero,
   input  logic mod_on,
   input  logic mod_gate,
   output logic phase_q,
   output logic bz_q
);
   logic gate_idle;
   logic phase_nxt;
   logic bz_nxt;

   if (GATE_ACTIVE_HIGH) begin : g_gate_hi
      assign gate_idle = !mod_gate;
   end else begin : g_gate_lo
      assign gate_idle = mod_gate;
   end

   always_comb begin
      if (zero) begin
         phase_nxt = 1'b1;
      end else if (term) begin
         phase_nxt = !phase_q;
      end else begin
         phase_nxt = phase_q;
      end
   end

   always_comb begin
      if (zero) begin
         bz_nxt = 1'b1;
      end else if (!run) begin
         bz_nxt = bz_q;
      end else if (mod_on && gate_idle) begin
         bz_nxt = 1'b1;
      end else begin
         bz_nxt = phase_nxt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b1;
         bz_q    <= 1'b1;
      end else begin
         phase_q <= phase_nxt;
         bz_q    <= bz_nxt;
      end
   end
endmodule

// File: rtl/buzz_tone_gen.sv
module buzz_tone_gen
   import buzz_pkg::*;
#(
   parameter int DIV_W            = 16,
   parameter int ADDR_W           = 2,
   parameter bit GATE_ACTIVE_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              mod_gate,
   output logic              bz_out
);
   localparam int NBYTES = DIV_W / BYTE_W;

   if ((DIV_W % BYTE_W) != 0 || DIV_W < 2 * BYTE_W) begin : g_bad_width
      $error("DIV_W must be a whole number of bytes, at least two");
   end
   if ((1 << ADDR_W) < NBYTES + 1) begin : g_bad_addr
      $error("ADDR_W too narrow for the byte and configuration addresses");
   end

   logic [DIV_W-1:0]        live_val;
   logic [DIV_W-BYTE_W-1:0] shadow_val;
   logic                    live_zero;
   buzz_cfg_t               cfg_q;
   logic                    run_on;
   logic                    mod_on;
   logic                    term;
   logic                    phase_q;
   logic                    bz_q;

   buzz_regs #(.DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .live_val   (live_val),
      .shadow_val (shadow_val),
      .live_zero  (live_zero),
      .cfg_q      (cfg_q)
   );

   assign run_on = cfg_q.run_on;
   assign mod_on = cfg_q.mod_on;

   buzz_divider #(.DIV_W(DIV_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .run      (run_on),
      .zero     (live_zero),
      .load_val (live_val),
      .term     (term)
   );

   buzz_out_stage #(.GATE_ACTIVE_HIGH(GATE_ACTIVE_HIGH)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .term     (term),
      .run      (run_on),
      .zero     (live_zero),
      .mod_on   (mod_on),
      .mod_gate (mod_gate),
      .phase_q  (phase_q),
      .bz_q     (bz_q)
   );

   assign bz_out = bz_q;
endmodule

// File: rtl/buzz_tone_chk.sv
module buzz_tone_chk #(
   parameter int DIV_W            = 16,
   parameter int ADDR_W           = 2,
   parameter bit GATE_ACTIVE_HIGH = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [7:0]        wr_data,
   input logic              mod_gate,
   input logic              bz_out,
   input logic [DIV_W-1:0]  live_val,
   input logic [DIV_W-9:0]  shadow_val,
   input logic              run_on,
   input logic              mod_on,
   input logic              phase_q
);
   localparam int NBYTES = DIV_W / 8;
   localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NBYTES - 1);

   logic gate_idle;
   assign gate_idle = GATE_ACTIVE_HIGH ? !mod_gate : mod_gate;

   p_low_write_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr < TOP_ADDR)) |=> $stable(live_val));

   p_top_write_commits_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr == TOP_ADDR)) |=> (live_val == {$past(wr_data), $past(shadow_val)}));

   p_zero_forces_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (live_val == '0) |=> bz_out);

   p_freeze_when_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_on && (live_val != '0)) |=> $stable(bz_out));

   p_idle_gate_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run_on && mod_on && gate_idle && (live_val != '0)) |=> bz_out);

   p_phase_needs_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase_q != $past(phase_q)) && ($past(live_val) != '0)) |-> $past(tick_en));
endmodule

bind buzz_tone_gen buzz_tone_chk #(
   .DIV_W(DIV_W), .ADDR_W(ADDR_W), .GATE_ACTIVE_HIGH(GATE_ACTIVE_HIGH)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_en    (tick_en),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .mod_gate   (mod_gate),
   .bz_out     (bz_out),
   .live_val   (live_val),
   .shadow_val (shadow_val),
   .run_on     (run_on),
   .mod_on     (mod_on),
   .phase_q    (phase_q)
);

// File: tb/buzz_tone_gen_test.sv
module buzz_tone_gen_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       mod_gate = 1'b0;
   logic       bz_out;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   buzz_tone_gen uut (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .mod_gate(mod_gate), .bz_out(bz_out)
   );

   // {divider value, expected half period in cycles}
   localparam logic [31:0] VEC [5] = '{
      {16'h0001, 16'd2},
      {16'h0002, 16'd3},
      {16'h0005, 16'd6},
      {16'h0017, 16'd24},
      {16'h0100, 16'd257}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // called just after a falling edge; returns just after a falling edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_div(input logic [15:0] v);
      wr(2'd0, v[7:0]);
      wr(2'd1, v[15:8]);
   endtask

   task automatic wait_change(output int c);
      logic prev;
      prev = bz_out;
      c = 0;
      do begin
         @(negedge clk);
         c++;
      end while (bz_out == prev && c < 70000);
   endtask

   task automatic count_changes(input int cycles, output int ch);
      logic prev;
      ch = 0;
      prev = bz_out;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (bz_out != prev) ch++;
         prev = bz_out;
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      int c, c2, ch;
      logic lvl;
      repeat (3) @(negedge clk);
      check(bz_out === 1'b1, "R9 reset output", bz_out, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R10: run bit on, value still zero -> R3 high
      wr(2'd2, 8'h01);
      tick_en = 1'b1;
      count_changes(20, ch);
      check(ch == 0 && bz_out === 1'b1, "R3 zero value holds high", ch, 0);

      // table walk: R4 / R2
      for (int i = 0; i < 5; i++) begin
         set_div(VEC[i][31:16]);
         wait_change(c); wait_change(c);
         wait_change(c);
         check(c == int'(VEC[i][15:0]), "R4 half period a", c, int'(VEC[i][15:0]));
         wait_change(c);
         check(c == int'(VEC[i][15:0]), "R4 half period b", c, int'(VEC[i][15:0]));
      end

      // R1: low write alone keeps the period
      set_div(16'h0003);
      wait_change(c); wait_change(c);
      wr(2'd0, 8'h50);
      wait_change(c); wait_change(c);
      check(c == 4, "R1 low byte buffered only", c, 4);
      // R2: top write commits 0x0050
      wr(2'd1, 8'h00);
      wait_change(c); wait_change(c);
      wait_change(c);
      check(c == 81, "R2 commit with buffered byte", c, 81);

      // R3: back to zero -> high
      set_div(16'h0000);
      @(negedge clk);
      count_changes(30, ch);
      check(ch == 0 && bz_out === 1'b1, "R3 zero after running", ch, 0);

      // R5 / R11: first tick after commit drives low
      tick_en = 1'b0;
      set_div(16'h0004);
      count_changes(10, ch);
      check(ch == 0 && bz_out === 1'b1, "R11 no tick no motion", ch, 0);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      check(bz_out === 1'b0, "R5 first tick low", bz_out, 0);

      // R11: tick every third cycle, N=1 -> 6 cycles
      set_div(16'h0001);
      fork
         begin
            for (int j = 0; j < 200; j++) begin
               tick_en = (j % 3 == 0);
               @(negedge clk);
            end
            tick_en = 1'b0;
         end
         begin
            wait_change(c); wait_change(c);
            wait_change(c);
            check(c == 6, "R11 sparse tick period", c, 6);
         end
      join
      tick_en = 1'b1;

      // R8: change mid-count
      set_div(16'h0009);
      wait_change(c); wait_change(c);
      wr(2'd0, 8'h02);
      wait_change(c);
      wr(2'd1, 8'h00);
      wait_change(c2);
      check(c2 + 1 == 10, "R8 old ratio finishes", c2 + 1, 10);
      wait_change(c);
      check(c == 3, "R8 new ratio after reload", c, 3);

      // R6: freeze and resume
      set_div(16'h0003);
      wait_change(c);
      wr(2'd2, 8'h00);
      lvl = bz_out;
      count_changes(40, ch);
      check(ch == 0 && bz_out == lvl, "R6 frozen level", ch, 0);
      wr(2'd2, 8'h01);
      count_changes(20, ch);
      check(ch > 0, "R6 resumes after run set", ch, 1);

      // R7: modulation gate
      set_div(16'h0001);
      mod_gate = 1'b0;
      wr(2'd2, 8'h03);
      @(negedge clk);
      count_changes(20, ch);
      check(ch == 0 && bz_out === 1'b1, "R7 idle gate high", ch, 0);
      mod_gate = 1'b1;
      count_changes(20, ch);
      check(ch >= 8, "R7 active gate passes wave", ch, 10);
      mod_gate = 1'b0;
      wr(2'd2, 8'h01);
      count_changes(20, ch);
      check(ch >= 8, "R7 gate ignored without modulation", ch, 10);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule